// File: doc/BRIEF.md
# Video Feature Control Register Slave

This block is a two-wire serial slave that holds the user settings of a picture-sharpness processor, together with a short readback path for status and two converter results. A host writes a subaddress byte followed by data bytes. The data bytes fill a mode register and four 6-bit level registers. The slave steps the subaddress after each byte. A read ignores the subaddress. It always returns the status byte first, then the two converter bytes, and then it wraps back to status.

A board strap sets two bits of the slave address, so two parts can share one bus. A mode bit in the control register chooses where the feature outputs come from. When the bit is clear, the outputs follow a set of pin-side inputs. When the bit is set, the outputs follow the registers. The status byte carries a sticky supply-loss flag. The flag is set at reset and by a supply-fail pulse, and a completed status read clears it.

Both bus lines are sampled through synchronisers on the system clock. The data line is driven only through an open-drain enable. The slave does not stretch the clock and does not support 10-bit addressing.

Top module: `vidreg_i2c_slave`

## Requirements
- R1: The slave address is {strap,1,strap,0,0,0,0}, so the address byte is 40h/41h with strap 0 and E0h/E1h with strap 1. A matching address byte is acknowledged by pulling the data line low in the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: After reset the data line is released, the mode bit and all level registers are zero, and the supply-loss flag is 1.
- R3: In a write, the first byte after the address is the subaddress. Each following byte lands at the current subaddress, which then steps by one. Subaddress 0 holds the control bits: bit0 is the host-mode select, bit1 the amplitude select, bit2 the line-rate select and bit3 the filter select. Subaddresses 1, 2, 3 and 4 hold the peaking, steepness, coring and width levels in bits 5..0. A write to one subaddress leaves the other registers unchanged.
- R4: A byte written after subaddress 4, or to any subaddress above 4, is acknowledged and discarded. The stepping does not wrap back to 0.
- R5: A read always starts at the status byte, whatever subaddress was written before it. Further bytes follow in the order converter byte 1, converter byte 2, and then status again.
- R6: The status byte reads as {4'b0000, ID = 3'b000, flag}.
- R7: A supply-fail pulse sets the flag. The flag clears only after a status byte has been sent and the master's acknowledge bit has been sampled. A status read taken while the flag is set returns it as 1.
- R8: When host mode is 0, the feature outputs equal the pin-side inputs. When host mode is 1, they equal the register contents.
- R9: A not-acknowledge from the master after a read byte ends the transfer, and the slave releases the data line. A repeated start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| addr_strap | input | 1 | Address select strap |
| pwr_fail | input | 1 | Supply interruption pulse |
| adc1_byte | input | 8 | First converter readback byte |
| adc2_byte | input | 8 | Second converter readback byte |
| pin_amp | input | 1 | Pin-side amplitude select |
| pin_rate | input | 1 | Pin-side line-rate select |
| pin_filt | input | 1 | Pin-side filter select |
| pin_peak | input | 6 | Pin-side peaking level |
| pin_steep | input | 6 | Pin-side steepness level |
| pin_core | input | 6 | Pin-side coring level |
| pin_width | input | 6 | Pin-side width level |
| host_mode | output | 1 | Current control-source select |
| amp_sel | output | 1 | Effective amplitude select |
| rate_sel | output | 1 | Effective line-rate select |
| filt_sel | output | 1 | Effective filter select |
| peak_lvl | output | 6 | Effective peaking level |
| steep_lvl | output | 6 | Effective steepness level |
| core_lvl | output | 6 | Effective coring level |
| width_lvl | output | 6 | Effective width level |

## Verification
The bench builds the block with its default parameters: 6-bit levels, ID code 000 and a two-stage synchroniser. With a bus quarter-period of five system clocks, every synchronised edge lands well inside a bus phase. The bench drives both strap values, so both address patterns are exercised. It uses level bytes whose upper bits are set, so the 6-bit truncation is checked. It runs the write past subaddress 4, runs the read past the wrap back to status, and places supply-fail pulses between reads so that both the set and the clear of the flag are seen at the port.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RECV, PH_ACK_OUT, PH_SEND, PH_ACK_IN
    } phase_e;

    typedef enum logic [1:0] {
        ROLE_ADDR, ROLE_SUB, ROLE_DATA, ROLE_READ
    } role_e;

    // control byte layout, LSB first: host, amp, rate, filt
    typedef struct packed {
        logic filt;
        logic rate;
        logic amp;
        logic host;
    } mode_t;

    localparam int LAST_SUB = 4;
    localparam int LAST_RD  = 2;

    function automatic logic [6:0] dev_addr(input logic strap);
        return {strap, 1'b1, strap, 4'b0000};
    endfunction

endpackage

// File: rtl/vidreg_line_sync.sv
module vidreg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/vidreg_link.sv
module vidreg_link
    import vidreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [6:0] my_addr,
    input  logic [7:0] rd_byte,
    output logic [1:0] rd_sel,
    output logic       stat_done,
    output logic       wr_stb,
    output logic [2:0] wr_sub,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    phase_e     phase;
    role_e      role;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txbyte;
    logic [2:0] sub;
    logic       nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE; role <= ROLE_ADDR; bitcnt <= '0;
            shreg <= '0; txbyte <= '0; sub <= '0; nack <= 1'b0;
            rd_sel <= '0; stat_done <= 1'b0; wr_stb <= 1'b0;
            wr_sub <= '0; wr_data <= '0; sda_oe <= 1'b0;
        end else begin
            wr_stb    <= 1'b0;
            stat_done <= 1'b0;
            if (start_det) begin
                phase <= PH_RECV; role <= ROLE_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase <= PH_IDLE; sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RECV: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            unique case (role)
                                ROLE_ADDR: begin
                                    if (shreg[7:1] == my_addr) begin
                                        sda_oe <= 1'b1;
                                        phase  <= PH_ACK_OUT;
                                        role   <= shreg[0] ? ROLE_READ : ROLE_SUB;
                                        rd_sel <= '0;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                ROLE_SUB: begin
                                    sub    <= (shreg > 8'(LAST_SUB)) ? 3'(LAST_SUB + 1) : shreg[2:0];
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK_OUT;
                                    role   <= ROLE_DATA;
                                end
                                ROLE_DATA: begin
                                    if (sub <= 3'(LAST_SUB)) begin
                                        wr_stb  <= 1'b1;
                                        wr_sub  <= sub;
                                        wr_data <= shreg;
                                        sub     <= sub + 3'd1;
                                    end
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK_OUT;
                                end
                                default: phase <= PH_IDLE;
                            endcase
                        end
                    end
                    PH_ACK_OUT: begin
                        if (scl_fall) begin
                            if (role == ROLE_READ) begin
                                txbyte <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                phase  <= PH_SEND;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RECV;
                            end
                        end
                    end
                    PH_SEND: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                                phase  <= PH_ACK_IN;
                            end else begin
                                txbyte <= {txbyte[6:0], 1'b0};
                                sda_oe <= ~txbyte[6];
                            end
                        end
                    end
                    PH_ACK_IN: begin
                        if (scl_rise) begin
                            nack      <= sda_lvl;
                            stat_done <= (rd_sel == 2'd0);
                            rd_sel    <= (rd_sel == 2'(LAST_RD)) ? 2'd0 : rd_sel + 2'd1;
                        end else if (scl_fall) begin
                            if (nack) begin
                                phase <= PH_IDLE;
                            end else begin
                                txbyte <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                phase  <= PH_SEND;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R9: an idle slave never holds the data line
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);
    // R4: write pointer saturates one past the last register
    p_sub_cap_r4: assert property (@(posedge clk) disable iff (rst)
        sub <= 3'(LAST_SUB + 1));
    // R5: read selector stays within the three output bytes
    p_rd_range_r5: assert property (@(posedge clk) disable iff (rst)
        rd_sel <= 2'(LAST_RD));
    // R4: no write strobe carries a subaddress past the end
    p_wr_sub_ok_r4: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> wr_sub <= 3'(LAST_SUB));
endmodule

// File: rtl/vidreg_i2c_slave.sv
module vidreg_i2c_slave
    import vidreg_pkg::*;
#(
    parameter int         LVL_W  = 6,
    parameter logic [2:0] ID_VAL = 3'b000,
    parameter int         SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_strap,
    input  logic             pwr_fail,
    input  logic [7:0]       adc1_byte,
    input  logic [7:0]       adc2_byte,
    input  logic             pin_amp,
    input  logic             pin_rate,
    input  logic             pin_filt,
    input  logic [LVL_W-1:0] pin_peak,
    input  logic [LVL_W-1:0] pin_steep,
    input  logic [LVL_W-1:0] pin_core,
    input  logic [LVL_W-1:0] pin_width,
    output logic             host_mode,
    output logic             amp_sel,
    output logic             rate_sel,
    output logic             filt_sel,
    output logic [LVL_W-1:0] peak_lvl,
    output logic [LVL_W-1:0] steep_lvl,
    output logic [LVL_W-1:0] core_lvl,
    output logic [LVL_W-1:0] width_lvl
);
    localparam int NLVL = LAST_SUB;

    logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [1:0] rd_sel;
    logic       stat_done, wr_stb;
    logic [2:0] wr_sub;
    logic [7:0] wr_data, rd_byte;
    mode_t      ctl_q;
    logic       pwr_flag;
    logic [LVL_W-1:0] lvl_q [NLVL];

    vidreg_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    vidreg_link u_link (
        .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .my_addr(dev_addr(addr_strap)), .rd_byte(rd_byte), .rd_sel(rd_sel),
        .stat_done(stat_done), .wr_stb(wr_stb), .wr_sub(wr_sub),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)                          ctl_q <= '0;
        else if (wr_stb && wr_sub == 3'd0) ctl_q <= mode_t'(wr_data[3:0]);
    end

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)                                lvl_q[i] <= '0;
            else if (wr_stb && wr_sub == 3'(i + 1)) lvl_q[i] <= wr_data[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            pwr_flag <= 1'b1;
        else if (pwr_fail)  pwr_flag <= 1'b1;
        else if (stat_done) pwr_flag <= 1'b0;
    end

    always_comb begin
        unique case (rd_sel)
            2'd1:    rd_byte = adc1_byte;
            2'd2:    rd_byte = adc2_byte;
            default: rd_byte = {4'b0000, ID_VAL, pwr_flag};
        endcase
    end

    assign host_mode = ctl_q.host;
    assign amp_sel   = ctl_q.host ? ctl_q.amp  : pin_amp;
    assign rate_sel  = ctl_q.host ? ctl_q.rate : pin_rate;
    assign filt_sel  = ctl_q.host ? ctl_q.filt : pin_filt;
    assign peak_lvl  = ctl_q.host ? lvl_q[0] : pin_peak;
    assign steep_lvl = ctl_q.host ? lvl_q[1] : pin_steep;
    assign core_lvl  = ctl_q.host ? lvl_q[2] : pin_core;
    assign width_lvl = ctl_q.host ? lvl_q[3] : pin_width;

    // R7: a supply-fail pulse always leaves the flag set
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> pwr_flag);
    // R7: the flag only drops right after a completed status byte
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_flag) |-> $past(stat_done));
    // R3: control register moves only on a write strobe
    p_ctl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(ctl_q));
endmodule

// File: tb/vidreg_i2c_slave_test.sv
module vidreg_i2c_slave_test;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, m_low = 1'b0;
    logic sda_oe, addr_strap = 1'b0, pwr_fail = 1'b0;
    logic [7:0] adc1_byte = 8'h5A, adc2_byte = 8'hC3;
    logic pin_amp = 1'b1, pin_rate = 1'b0, pin_filt = 1'b1;
    logic [5:0] pin_peak = 6'h15, pin_steep = 6'h2B, pin_core = 6'h07, pin_width = 6'h31;
    logic host_mode, amp_sel, rate_sel, filt_sel;
    logic [5:0] peak_lvl, steep_lvl, core_lvl, width_lvl;
    wire sda_bus = ~(m_low | sda_oe);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vidreg_i2c_slave uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_strap(addr_strap), .pwr_fail(pwr_fail),
        .adc1_byte(adc1_byte), .adc2_byte(adc2_byte),
        .pin_amp(pin_amp), .pin_rate(pin_rate), .pin_filt(pin_filt),
        .pin_peak(pin_peak), .pin_steep(pin_steep), .pin_core(pin_core),
        .pin_width(pin_width), .host_mode(host_mode), .amp_sel(amp_sel),
        .rate_sel(rate_sel), .filt_sel(filt_sel), .peak_lvl(peak_lvl),
        .steep_lvl(steep_lvl), .core_lvl(core_lvl), .width_lvl(width_lvl)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        m_low = 1'b0; tick(2 * Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q);
            scl_m = 1'b1;  tick(2 * Q);
            scl_m = 1'b0;  tick(Q);
        end
        m_low = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1;
            tick(Q); b[i] = sda_bus;
            tick(Q); scl_m = 1'b0;
            tick(Q);
        end
        m_low = give_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    task automatic write_regs(input logic [7:0] dev, input logic [7:0] sub,
                              input logic [7:0] d[], input string tag);
        logic a;
        bus_start;
        wbyte(dev, a); check({tag, " addr ack"}, 8'(a), 8'h1);
        wbyte(sub, a); check({tag, " sub ack"}, 8'(a), 8'h1);
        foreach (d[k]) begin
            wbyte(d[k], a); check({tag, " data ack"}, 8'(a), 8'h1);
        end
        bus_stop;
    endtask

    task automatic t_reset;
        check("R2 sda released", 8'(sda_oe), 8'h0);
        check("R2 host mode", 8'(host_mode), 8'h0);
        check("R8 peak from pin", 8'(peak_lvl), 8'h15);
        check("R8 amp from pin", 8'(amp_sel), 8'h1);
    endtask

    task automatic t_address;
        logic a;
        bus_start; wbyte(8'hE0, a); bus_stop;
        check("R1 wrong address not acked", 8'(a), 8'h0);
        check("R1 line released", 8'(sda_oe), 8'h0);
        bus_start; wbyte(8'h40, a); bus_stop;
        check("R1 strap0 address acked", 8'(a), 8'h1);
    endtask

    task automatic t_burst;
        write_regs(8'h40, 8'h00, '{8'h0F, 8'hE1, 8'h12, 8'h3F, 8'h45}, "R3 burst");
        check("R3 host mode", 8'(host_mode), 8'h1);
        check("R3 amp rate filt", {5'b0, filt_sel, rate_sel, amp_sel}, 8'h07);
        check("R3 peak", 8'(peak_lvl), 8'h21);
        check("R3 steep", 8'(steep_lvl), 8'h12);
        check("R3 core", 8'(core_lvl), 8'h3F);
        check("R3 width", 8'(width_lvl), 8'h05);
    endtask

    task automatic t_single;
        write_regs(8'h40, 8'h03, '{8'h0A}, "R3 single");
        check("R3 single core", 8'(core_lvl), 8'h0A);
        check("R3 single peak kept", 8'(peak_lvl), 8'h21);
        check("R3 single width kept", 8'(width_lvl), 8'h05);
    endtask

    task automatic t_overflow;
        write_regs(8'h40, 8'h04, '{8'h11, 8'h22, 8'h33}, "R4 overrun");
        check("R4 width first byte", 8'(width_lvl), 8'h11);
        check("R4 no wrap to control", 8'(host_mode), 8'h1);
        check("R4 peak untouched", 8'(peak_lvl), 8'h21);
        write_regs(8'h40, 8'h07, '{8'h2A}, "R4 high sub");
        check("R4 high sub no effect peak", 8'(peak_lvl), 8'h21);
        check("R4 high sub no effect steep", 8'(steep_lvl), 8'h12);
    endtask

    task automatic t_read;
        logic a; logic [7:0] b;
        bus_start; wbyte(8'h41, a);
        check("R1 read address acked", 8'(a), 8'h1);
        rbyte(1'b1, b); check("R6 R7 status after reset", b, 8'h01);
        rbyte(1'b1, b); check("R5 adc1", b, 8'h5A);
        rbyte(1'b1, b); check("R5 adc2", b, 8'hC3);
        rbyte(1'b0, b); check("R5 R7 wrapped status cleared", b, 8'h00);
        check("R9 released after nack", 8'(sda_oe), 8'h0);
        bus_stop;
    endtask

    task automatic t_sub_ignored;
        logic a; logic [7:0] b;
        bus_start; wbyte(8'h40, a); wbyte(8'h02, a);
        bus_start; wbyte(8'h41, a);
        check("R9 repeated start acked", 8'(a), 8'h1);
        rbyte(1'b1, b); check("R5 read ignores subaddress", b, 8'h00);
        rbyte(1'b0, b); check("R5 then adc1", b, 8'h5A);
        bus_stop;
    endtask

    task automatic t_pwrfail;
        logic a; logic [7:0] b;
        @(negedge clk) pwr_fail = 1'b1;
        @(negedge clk) pwr_fail = 1'b0;
        bus_start; wbyte(8'h41, a); rbyte(1'b0, b); bus_stop;
        check("R7 flag set by pulse", b, 8'h01);
        bus_start; wbyte(8'h41, a); rbyte(1'b0, b); bus_stop;
        check("R7 flag cleared by read", b, 8'h00);
    endtask

    task automatic t_strap1;
        logic a;
        addr_strap = 1'b1; tick(2);
        bus_start; wbyte(8'h40, a); bus_stop;
        check("R1 strap1 ignores 40h", 8'(a), 8'h0);
        write_regs(8'hE0, 8'h01, '{8'h07}, "R1 strap1");
        check("R1 strap1 write lands", 8'(peak_lvl), 8'h07);
        addr_strap = 1'b0; tick(2);
    endtask

    task automatic t_pins;
        write_regs(8'h40, 8'h00, '{8'h0E}, "R8 pin mode");
        check("R8 host mode off", 8'(host_mode), 8'h0);
        check("R8 peak follows pin", 8'(peak_lvl), 8'h15);
        check("R8 width follows pin", 8'(width_lvl), 8'h31);
        check("R8 rate follows pin", 8'(rate_sel), 8'h0);
    endtask

    initial begin
        tick(5); rst = 1'b0; tick(5);
        t_reset;
        t_address;
        t_burst;
        t_single;
        t_overflow;
        t_read;
        t_sub_ignored;
        t_pwrfail;
        t_strap1;
        t_pins;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule